// File: doc/BRIEF.md
# ASCII Digit Word to Binary Converter

This block takes one 32-bit word made of four ASCII characters and returns a 16-bit binary value. Each character is first turned into a 4-bit nibble by its own decoder. In hex mode the four nibbles are packed side by side. In decimal mode the same nibbles are read as decimal digits. Three weighted lookup tables give the thousands, hundreds and tens parts, and these are added to the units digit. A 2:1 mux picks the result for the selected mode.

A word is taken in on a cycle with `in_valid` high. The converted value appears on `result`, with `out_valid`, after one clock edge. A two-state controller sequences the output. `ST_IDLE` holds `out_valid` low. `ST_PRESENT` holds it high for a cycle after a capture. The transition `capture` (ST_IDLE or ST_PRESENT to ST_PRESENT) is taken whenever `in_valid` is high. The transition `drain` (ST_PRESENT or ST_IDLE to ST_IDLE) is taken whenever it is low. Characters outside the two valid ranges, and letters in decimal mode, give an unspecified result.

Top module: `ascii_word_conv`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `out_valid` is 0 when no capture has occurred.
- R2: `out_valid` is 1 in the cycle after each cycle with `in_valid` high, including back-to-back captures, and 0 after a cycle with `in_valid` low.
- R3: With `mode_dec` = 0, characters 0x30..0x39 map to nibbles 0..9. Byte [31:24] goes to `result[15:12]`, byte [23:16] to [11:8], byte [15:8] to [7:4] and byte [7:0] to [3:0].
- R4: With `mode_dec` = 0, characters 0x41..0x46 map to nibbles 10..15 in the same positions, so 0x46464646 gives 0xFFFF.
- R5: With `mode_dec` = 1 and all bytes in 0x30..0x39, `result` = 1000·d3 + 100·d2 + 10·d1 + d0, where d3 comes from byte [31:24] and d0 from byte [7:0]. For example, 0x35333231 gives 0x14C9.
- R6: `result` keeps its last captured value while `in_valid` is low, whatever `char_word` does.
- R7: `mode_dec` is sampled only together with the word. A change of mode while `in_valid` is low does not alter `result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Capture strobe for `char_word` and `mode_dec` |
| mode_dec | input | 1 | 0 selects hex packing, 1 selects decimal conversion |
| char_word | input | 32 | Four ASCII characters, leading character in bits [31:24] |
| out_valid | output | 1 | Result-valid strobe, one cycle after capture |
| result | output | 16 | Converted binary value |

## Verification
The value assertions assume that every byte presented with `in_valid` lies in 0x30..0x39 or 0x41..0x46. The decimal and hex-digit properties only fire when all four bytes are decimal digits. The bench builds each word from a character index rather than from raw bytes, so every word stays in the valid set. Letters are only ever driven in hex mode. While `in_valid` is low the bench drives arbitrary valid words and mode flips, to show they are ignored.

// File: rtl/ascii_conv_pkg.sv
package ascii_conv_pkg;
    localparam int CHAR_W = 8;
    localparam int NIB_W  = 4;

    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_PRESENT = 1'b1
    } conv_state_e;
endpackage

// File: rtl/char_to_nibble.sv
module char_to_nibble
    import ascii_conv_pkg::*;
(
    input  logic [CHAR_W-1:0] char_in,
    output logic [NIB_W-1:0]  nibble
);
    // Letters 'A'..'F' sit at 0x41..0x46: low nibble 1..6, plus 9 gives 10..15
    always_comb begin
        if (char_in >= 8'h41)
            nibble = char_in[NIB_W-1:0] + NIB_W'(9);
        else
            nibble = char_in[NIB_W-1:0];
    end
endmodule

// File: rtl/dec_weight_rom.sv
module dec_weight_rom
    import ascii_conv_pkg::*;
#(
    parameter int unsigned WEIGHT = 10,
    parameter int          OUT_W  = 16
) (
    input  logic [NIB_W-1:0] digit,
    output logic [OUT_W-1:0] value
);
    // Sixteen-entry table; entries above 9 are never used in decimal mode
    logic [OUT_W-1:0] table_q [2**NIB_W];

    generate
        for (genvar k = 0; k < 2**NIB_W; k++) begin : g_entry
            localparam int unsigned ENTRY = (k <= 9) ? k * WEIGHT : 0;
            assign table_q[k] = OUT_W'(ENTRY);
        end
    endgenerate

    assign value = table_q[digit];
endmodule

// File: rtl/ascii_word_conv.sv
module ascii_word_conv
    import ascii_conv_pkg::*;
#(
    parameter int CHARS = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    input  logic                      mode_dec,
    input  logic [CHARS*CHAR_W-1:0]   char_word,
    output logic                      out_valid,
    output logic [CHARS*NIB_W-1:0]    result
);
    localparam int OUT_W = CHARS * NIB_W;

    logic [NIB_W-1:0] nib      [CHARS];
    logic [OUT_W-1:0] weighted [CHARS];
    logic [OUT_W-1:0] hex_val;
    logic [OUT_W-1:0] dec_val;
    logic [OUT_W-1:0] mux_val;

    conv_state_e state_q, state_d;

    // One decoder per character; index 0 is the last (units) character
    generate
        for (genvar i = 0; i < CHARS; i++) begin : g_char
            char_to_nibble dec_u (
                .char_in (char_word[i*CHAR_W +: CHAR_W]),
                .nibble  (nib[i])
            );
            assign hex_val[i*NIB_W +: NIB_W] = nib[i];

            if (i == 0) begin : g_units
                assign weighted[i] = OUT_W'(nib[i]);
            end else begin : g_rom
                localparam int unsigned WGT = 10 ** i;
                dec_weight_rom #(.WEIGHT(WGT), .OUT_W(OUT_W)) rom_u (
                    .digit (nib[i]),
                    .value (weighted[i])
                );
            end
        end
    endgenerate

    always_comb begin
        dec_val = '0;
        for (int j = 0; j < CHARS; j++)
            dec_val = dec_val + weighted[j];
    end

    assign mux_val = mode_dec ? dec_val : hex_val;

    // Controller: state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE:    state_d = in_valid ? ST_PRESENT : ST_IDLE;
            ST_PRESENT: state_d = in_valid ? ST_PRESENT : ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Output process
    always_ff @(posedge clk) begin
        if (rst)           result <= '0;
        else if (in_valid) result <= mux_val;
    end

    assign out_valid = (state_q == ST_PRESENT);
endmodule

// File: rtl/ascii_word_conv_chk.sv
module ascii_word_conv_chk
    import ascii_conv_pkg::*;
#(
    parameter int CHARS = 4
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    in_valid,
    input logic                    mode_dec,
    input logic [CHARS*CHAR_W-1:0] char_word,
    input logic                    out_valid,
    input logic [CHARS*NIB_W-1:0]  result
);
    localparam int OUT_W = CHARS * NIB_W;

    function automatic logic all_digits(input logic [CHARS*CHAR_W-1:0] w);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < CHARS; i++)
            if (w[i*CHAR_W +: CHAR_W] < 8'h30 || w[i*CHAR_W +: CHAR_W] > 8'h39)
                ok = 1'b0;
        return ok;
    endfunction

    function automatic logic [OUT_W-1:0] digit_pack(input logic [CHARS*CHAR_W-1:0] w);
        logic [OUT_W-1:0] v;
        for (int i = 0; i < CHARS; i++)
            v[i*NIB_W +: NIB_W] = w[i*CHAR_W +: NIB_W];
        return v;
    endfunction

    function automatic int unsigned dec_max();
        int unsigned m;
        m = 1;
        for (int i = 0; i < CHARS; i++) m = m * 10;
        return m - 1;
    endfunction

    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> !out_valid);

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R2
    valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result));

    // R3
    hex_digit_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !mode_dec && all_digits(char_word))
        |=> result == digit_pack($past(char_word)));

    // R5
    dec_range_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode_dec && all_digits(char_word))
        |=> 32'(result) <= dec_max());
endmodule

bind ascii_word_conv ascii_word_conv_chk #(.CHARS(CHARS)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .mode_dec  (mode_dec),
    .char_word (char_word),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/ascii_word_conv_tb_top.sv
`timescale 1ns/1ps
module ascii_word_conv_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        mode_dec = 1'b0;
    logic [31:0] char_word = 32'h3030_3030;
    logic        out_valid;
    logic [15:0] result;

    int n_cmp  = 0;
    int n_bad  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    ascii_word_conv #(.CHARS(4)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .mode_dec  (mode_dec),
        .char_word (char_word),
        .out_valid (out_valid),
        .result    (result)
    );

    task automatic chk(input string req, input int got, input int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    function automatic logic [7:0] idx_char(input int idx);
        return (idx < 10) ? 8'(8'h30 + idx) : 8'(8'h37 + idx);
    endfunction

    function automatic logic [31:0] dec_word(input int v);
        return {idx_char((v / 1000) % 10), idx_char((v / 100) % 10),
                idx_char((v / 10) % 10), idx_char(v % 10)};
    endfunction

    task automatic apply(input logic [31:0] w, input logic m);
        char_word = w;
        mode_dec  = m;
        in_valid  = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", out_valid, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", out_valid, 0);

        // R5: every four-digit decimal string, streamed back to back (R2)
        for (int v = 0; v < 10000; v++) begin
            apply(dec_word(v), 1'b1);
            chk("R2", out_valid, 1);
            chk("R5", result, v);
        end
        in_valid = 1'b0;
        @(negedge clk);
        chk("R2", out_valid, 0);

        // R3/R4: random valid hex strings
        for (int k = 0; k < 3000; k++) begin
            int a, b, c, d;
            a = int'($urandom_range(15)); b = int'($urandom_range(15));
            c = int'($urandom_range(15)); d = int'($urandom_range(15));
            apply({idx_char(a), idx_char(b), idx_char(c), idx_char(d)}, 1'b0);
            if (a > 9 || b > 9 || c > 9 || d > 9)
                chk("R4", result, (a << 12) | (b << 8) | (c << 4) | d);
            else
                chk("R3", result, (a << 12) | (b << 8) | (c << 4) | d);
        end

        apply(32'h4646_4646, 1'b0);
        chk("R4", result, 16'hFFFF);
        apply(32'h4142_4344, 1'b0);
        chk("R4", result, 16'hABCD);
        apply(32'h3533_3231, 1'b0);
        chk("R3", result, 16'h5321);
        apply(32'h3030_3030, 1'b0);
        chk("R3", result, 0);
        apply(32'h3533_3231, 1'b1);
        chk("R5", result, 16'h14C9);
        apply(32'h3939_3939, 1'b1);
        chk("R5", result, 16'h270F);

        // R6/R7: inputs ignored while in_valid is low
        apply(32'h3132_3334, 1'b1);
        chk("R5", result, 1234);
        in_valid = 1'b0;
        for (int k = 0; k < 4; k++) begin
            char_word = dec_word(9999 - k);
            mode_dec  = k[0];
            @(negedge clk);
            chk("R6", result, 1234);
            chk("R2", out_valid, 0);
        end
        mode_dec = 1'b0;
        @(negedge clk);
        chk("R7", result, 1234);
        apply(32'h3132_3334, 1'b0);
        chk("R7", result, 16'h1234);
        in_valid = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule